// File: doc/BRIEF.md
# Burst Read Responder with Local Word Store

This block answers read bursts on the read half of an AXI4 slave port. It holds a small word store inside itself, preset to a known pattern at reset. A master offers a command that carries a tag, a start byte address, a beat count, a beat size and an address-stepping kind. After the block accepts the command, it returns one data beat per accepted handshake. Each beat carries the tag, a full data word, a status code and an end-of-burst marker.

The block works one burst at a time. It lowers its command-ready line for as long as a burst is in progress. Each beat is formed from registered burst state, so the beat stays fixed while the master applies back-pressure. After the first beat, the block works out every address from the captured size, count and kind. A beat that points past the end of the store still completes, but it carries zero data and an error status.

Top module: `axi_rd_slave`

## Requirements
- R1: `cmd_ready` is high exactly when reset is released and no burst is in progress. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A command offered during a burst waits until the burst ends.
- R2: While `rst_n` is low, every output is zero. Asserting `rst_n` in the middle of a burst abandons that burst.
- R3: `beat_valid` rises in the cycle after a command is taken, and never rises without a command having been taken.
- R4: While `beat_valid` is high and `beat_ready` is low, every beat output holds its value. The block moves to the next beat only after a cycle with both high.
- R5: A burst returns `cmd_len`+1 beats. `beat_last` is high only on the final beat. `cmd_ready` is high in the cycle after the final beat is accepted.
- R6: `beat_id` equals the `cmd_id` captured with the command, on every beat.
- R7: `cmd_kind` = 0 (fixed): every beat uses the start address.
- R8: `cmd_kind` = 1 (incrementing): the first beat uses the start address as given. Each later beat is the previous address aligned down to 2^`cmd_size` bytes, plus 2^`cmd_size`.
- R9: `cmd_kind` = 2 (wrapping): addresses step as in R8 but stay inside a window of (`cmd_len`+1)·2^`cmd_size` bytes, aligned to its own size. On passing the window's top, the address returns to the window's base. `cmd_len` is 1, 3, 7 or 15.
- R10: A beat returns the whole store word at index address/(DATA_W/8), whatever the beat size. Word i holds MEM_BASE + i·MEM_STEP, truncated to DATA_W; the defaults are 0x13570000 and 0x00010203.
- R11: A beat whose word index is below DEPTH has status 0 (OKAY). A beat at a higher index has zero data and status 2 (SLVERR), and the burst goes on to its normal end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_id | input | ID_W | Command tag |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | 8 | Beat count minus one |
| cmd_size | input | 3 | Log2 of bytes per beat |
| cmd_kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| beat_id | output | ID_W | Tag of the current beat |
| beat_data | output | DATA_W | Beat data word |
| beat_resp | output | 2 | Beat status, 0 OKAY or 2 SLVERR |
| beat_last | output | 1 | Final beat of the burst |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Master accepts the beat |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 16-bit address and a 32-word store. With four byte lanes, beat sizes 0 to 2 are legal, so narrow incrementing and narrow wrapping bursts can be exercised. The store covers only 128 bytes, so an ordinary address such as 0x100, or an incrementing burst that starts near 0x78, runs past the end and produces error beats in the middle of a burst. An 8-bit length allows a 256-beat burst that still finishes well within the run.

// File: rtl/axi_rd_slave.sv
module axi_rd_slave #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter logic [DATA_W-1:0] MEM_BASE = 'h1357_0000,
  parameter logic [DATA_W-1:0] MEM_STEP = 'h0001_0203
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_len,
  input  logic [2:0]        cmd_size,
  input  logic [1:0]        cmd_kind,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic [ID_W-1:0]   beat_id,
  output logic [DATA_W-1:0] beat_data,
  output logic [1:0]        beat_resp,
  output logic              beat_last,
  output logic              beat_valid,
  input  logic              beat_ready
);
  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = ADDR_W - LANE_W;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam logic [WORD_W-1:0] TOP = WORD_W'(DEPTH);
  localparam logic [1:0] K_FIXED = 2'd0;
  localparam logic [1:0] K_WRAP  = 2'd2;

  logic              busy;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        len_q, cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        kind_q;
  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] step, aligned, span, lower, nxt, addr_nx;
  logic [WORD_W-1:0] word;
  logic              in_range, final_beat;

  assign step    = ADDR_W'(1) << size_q;
  assign aligned = addr_q & ~(step - ADDR_W'(1));
  assign span    = step * (ADDR_W'(len_q) + ADDR_W'(1));
  assign lower   = addr_q & ~(span - ADDR_W'(1));
  assign nxt     = aligned + step;

  always_comb begin
    case (kind_q)
      K_FIXED: addr_nx = addr_q;
      K_WRAP:  addr_nx = lower | (nxt & (span - ADDR_W'(1)));
      default: addr_nx = nxt;
    endcase
  end

  assign word       = addr_q[ADDR_W-1:LANE_W];
  assign in_range   = word < TOP;
  assign final_beat = cnt_q == len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= MEM_BASE + DATA_W'(i) * MEM_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      id_q   <= '0;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      size_q <= '0;
      kind_q <= '0;
    end else if (!busy) begin
      if (cmd_valid) begin
        busy   <= 1'b1;
        id_q   <= cmd_id;
        addr_q <= cmd_addr;
        len_q  <= cmd_len;
        size_q <= cmd_size;
        kind_q <= cmd_kind;
        cnt_q  <= '0;
      end
    end else if (beat_ready) begin
      if (final_beat) begin
        busy <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 8'd1;
        addr_q <= addr_nx;
      end
    end
  end

  assign cmd_ready  = rst_n & ~busy;
  assign beat_valid = busy;
  assign beat_id    = busy ? id_q : '0;
  assign beat_data  = (busy && in_range) ? mem[word[IDX_W-1:0]] : '0;
  assign beat_resp  = (busy && !in_range) ? 2'b10 : 2'b00;
  assign beat_last  = busy & final_beat;
endmodule

// File: rtl/axi_rd_slave_chk.sv
module axi_rd_slave_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ID_W-1:0]   cmd_id,
  input logic [7:0]        cmd_len,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ID_W-1:0]   beat_id,
  input logic [DATA_W-1:0] beat_data,
  input logic [1:0]        beat_resp,
  input logic              beat_last,
  input logic              beat_valid,
  input logic              beat_ready
);
  logic [8:0] seen;
  logic [7:0] len_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= '0;
      len_c <= '0;
    end else if (cmd_valid && cmd_ready) begin
      seen  <= '0;
      len_c <= cmd_len;
    end else if (beat_valid && beat_ready) begin
      seen <= seen + 9'd1;
    end
  end

  assert_idle_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !beat_valid);

  always @(posedge clk)
    if (!rst_n)
      assert_reset_quiet_R2: assert (!cmd_ready && !beat_valid && !beat_last &&
                                     beat_id == '0 && beat_data == '0 && beat_resp == 2'b00);

  // R6 checked together with the first beat
  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> beat_valid && beat_id == $past(cmd_id));

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> $past(cmd_valid && cmd_ready));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_data) && $stable(beat_id) &&
                                  $stable(beat_last) && $stable(beat_resp));

  assert_last_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_last == (seen == {1'b0, len_c})));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> cmd_ready);

  assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_resp != 2'b00 |-> beat_resp == 2'b10 && beat_data == '0);
endmodule

bind axi_rd_slave axi_rd_slave_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_id(cmd_id), .cmd_len(cmd_len),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .beat_id(beat_id),
  .beat_data(beat_data), .beat_resp(beat_resp), .beat_last(beat_last),
  .beat_valid(beat_valid), .beat_ready(beat_ready)
);

// File: tb/axi_rd_slave_tb_top.sv
`timescale 1ns/1ps
module axi_rd_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_id = '0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_len = '0;
  logic [2:0]  cmd_size = '0;
  logic [1:0]  cmd_kind = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  beat_id;
  logic [31:0] beat_data;
  logic [1:0]  beat_resp;
  logic        beat_last;
  logic        beat_valid;
  logic        beat_ready = 1'b0;

  always #4 clk = ~clk;

  axi_rd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_id(cmd_id), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_kind(cmd_kind),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .beat_id(beat_id),
    .beat_data(beat_data), .beat_resp(beat_resp), .beat_last(beat_last),
    .beat_valid(beat_valid), .beat_ready(beat_ready)
  );

  typedef struct { int id; logic [31:0] data; int resp; bit last; } beat_t;
  beat_t q[$];
  bit    m_busy = 0;
  int    vectors = 0, misses = 0;
  string cur_tag = "R10";
  int    rmode = 0;
  int    cyc = 0;
  logic [7:0] lfsr = 8'hA5;

  function automatic logic [31:0] word_val(int w);
    if (w < 32) return 32'h1357_0000 + 32'(w) * 32'h0001_0203;
    return 32'h0;
  endfunction

  // Reference: expected beat list built from the command when it is taken
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_busy = 0;
    end else if (m_busy) begin
      if (beat_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) m_busy = 0;
      end
    end else if (cmd_valid) begin
      int bytes, total, a, base, al, ad, w;
      bytes = 1 << cmd_size;
      total = bytes * (int'(cmd_len) + 1);
      a     = int'(cmd_addr);
      al    = a - (a % bytes);
      base  = a - (a % total);
      for (int k = 0; k <= int'(cmd_len); k++) begin
        beat_t b;
        if (cmd_kind == 2'd0)      ad = a;
        else if (cmd_kind == 2'd2) ad = base + ((al - base) + k * bytes) % total;
        else                       ad = (k == 0) ? a : al + k * bytes;
        w      = ad / 4;
        b.id   = int'(cmd_id);
        b.data = word_val(w);
        b.resp = (w < 32) ? 0 : 2;
        b.last = (k == int'(cmd_len));
        q.push_back(b);
      end
      m_busy = 1;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    if (!rst_n) begin
      chk("R2", "cmd_ready", 64'(cmd_ready), 0);
      chk("R2", "beat_valid", 64'(beat_valid), 0);
      chk("R2", "beat_id", 64'(beat_id), 0);
      chk("R2", "beat_data", 64'(beat_data), 0);
      chk("R2", "beat_resp", 64'(beat_resp), 0);
      chk("R2", "beat_last", 64'(beat_last), 0);
    end else begin
      chk("R1", "cmd_ready", 64'(cmd_ready), 64'(!m_busy));
      chk("R3", "beat_valid", 64'(beat_valid), 64'(m_busy));
      if (m_busy && q.size() > 0) begin
        chk("R6", "beat_id", 64'(beat_id), 64'(q[0].id));
        chk(cur_tag, "beat_data", 64'(beat_data), 64'(q[0].data));
        chk("R11", "beat_resp", 64'(beat_resp), 64'(q[0].resp));
        chk("R5", "beat_last", 64'(beat_last), 64'(q[0].last));
      end else begin
        chk("R3", "idle beat_last", 64'(beat_last), 0);
        chk("R3", "idle beat_data", 64'(beat_data), 0);
      end
    end
  end

  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    case (rmode)
      0: beat_ready = 1'b1;
      1: begin
        beat_ready = lfsr[0];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      default: beat_ready = (cyc % 4 == 3);
    endcase
  end

  task automatic send(int id, int addr, int len, int size, int kind);
    @(posedge clk);
    #1;
    cmd_id = 4'(id); cmd_addr = 16'(addr); cmd_len = 8'(len);
    cmd_size = 3'(size); cmd_kind = 2'(kind); cmd_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (!m_busy && cmd_ready) break;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8: single beat, then unaligned incrementing start
    cur_tag = "R8";
    send(1, 'h10, 0, 2, 1); wait_idle();
    send(2, 'h22, 3, 2, 1); wait_idle();
    // R7 fixed kind under irregular back-pressure (R4)
    cur_tag = "R7"; rmode = 1;
    send(3, 'h40, 3, 2, 0); wait_idle();
    // R9 wrapping: full width, halfword, and sixteen beats
    cur_tag = "R9";
    send(4, 'h38, 3, 2, 2); wait_idle();
    send(5, 'h16, 7, 1, 2); wait_idle();
    send(6, 'h24, 15, 2, 2); wait_idle();
    // R10 narrow byte beats return whole words
    cur_tag = "R10"; rmode = 0;
    send(7, 'h05, 5, 0, 1); wait_idle();
    // R11 out-of-range and a burst running off the end of the store
    cur_tag = "R11";
    send(8, 'h100, 1, 2, 1); wait_idle();
    send(9, 'h78, 3, 2, 1); wait_idle();
    // R1 and R4: commands queued behind busy bursts with sparse ready
    cur_tag = "R4"; rmode = 2;
    send(10, 'h00, 2, 2, 1);
    send(11, 'h30, 1, 2, 2);
    send(12, 'h08, 0, 2, 0);
    wait_idle();
    // R5 longest burst
    cur_tag = "R5"; rmode = 0;
    send(13, 'h00, 255, 2, 1); wait_idle();
    // R2 reset in the middle of a burst
    cur_tag = "R2"; rmode = 2;
    send(14, 'h04, 20, 2, 1);
    repeat (6) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_tag = "R6"; rmode = 0;
    send(15, 'h0C, 2, 2, 1); wait_idle();
    repeat (3) @(posedge clk);
    summary();
    $finish;
  end
endmodule